// File: doc/BRIEF.md
# Banked Stack Pointer Selector

This block keeps the two stack pointers of a small processor core: a main pointer and a process pointer. At any moment one of them is the live stack pointer that the core reads and writes, and the other sits in a shadow register. The live pointer is the process pointer only when the core runs in thread mode (exception number zero) and the stack-select control bit is set. In every other state the main pointer is live.

The block does not swap the stored values whenever the select bit is written. It compares the effective choice before and after each update and exchanges the live and shadow registers only when that choice really changes. Because of this, an exception return can first load the select bit while the core is still in handler mode, and then write the new exception number. The swap, if any, happens at that second step. Software writes to the control bits, hardware writes of the select bit on exception entry and return, exception-number writes, stack-pointer writes and a pointer lookup by mode and select value are all handled in one clock domain.

Top module: `sp_bank_select`

## Requirements
- R1: The process pointer is live if and only if the registered exception number is zero and the registered select bit is 1. `using_process` shows this choice, and `sp_active` returns the live pointer's value.
- R2: The live and shadow registers are exchanged only when the effective choice of R1 differs between the start and the end of a cycle. Each named pointer (main or process) keeps its value across any number of selection changes.
- R3: A write through the exception-number port takes effect at the next clock edge. Moving between zero and non-zero with the select bit at 1 changes the live pointer. Moving from one non-zero value to another changes nothing.
- R4: A hardware select write (`hw_sel_we`, used with 0 on exception entry and with the return code on exception return) updates the select bit in any mode. In handler mode it leaves the live pointer unchanged.
- R5: A software control write updates the select bit only if the exception number at the start of the cycle is zero. Otherwise the bit keeps its value.
- R6: A software control write always updates the unprivileged bit, in any mode.
- R7: The lookup port returns the process pointer when `lk_thread`=1 and `lk_sel`=1, and returns the main pointer for the other three combinations. This holds whichever pointer is live.
- R8: A stack-pointer write stores `sp_wdata` with bits [1:0] cleared into the pointer that was live at the start of the cycle.
- R9: After reset, the exception number, select bit and unprivileged bit are 0, both pointers are 0, and the main pointer is live.
- R10: When several writes share a cycle, the hardware select write wins over the software one. Control writes are applied before the exception-number write. The swap decision is made once, against the combined final state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_ctl_we | input | 1 | Software control-register write strobe |
| sw_ctl_sel | input | 1 | Select bit value for a software write |
| sw_ctl_unpriv | input | 1 | Unprivileged bit value for a software write |
| hw_sel_we | input | 1 | Hardware select write (exception entry/return) |
| hw_sel_val | input | 1 | Select value for a hardware write |
| exc_we | input | 1 | Exception-number write strobe |
| exc_val | input | 9 | New exception number |
| sp_we | input | 1 | Stack-pointer write strobe |
| sp_wdata | input | 32 | Stack-pointer write data |
| lk_thread | input | 1 | Lookup: requested mode is thread |
| lk_sel | input | 1 | Lookup: requested select value |
| lk_data | output | 32 | Lookup result |
| sp_active | output | 32 | Value of the live stack pointer |
| using_process | output | 1 | Process pointer is live |
| sel_bit | output | 1 | Registered select bit |
| unpriv_bit | output | 1 | Registered unprivileged bit |
| exc_num | output | 9 | Registered exception number |

## Verification
A bad swap decision shows on `sp_active` in the cycle right after the edge where it happens. It also shows through the lookup port, because a main or process pointer read by name then returns the other pointer's value. The error stays in the design until the next swap or pointer write, so comparing every output against a model on each cycle catches it at once. A wrong mode check on software writes appears one cycle later on `sel_bit`, and a missed alignment clear appears on `sp_active` bits [1:0].

// File: rtl/sp_bank_pkg.sv
package sp_bank_pkg;

    typedef struct packed {
        logic sel;
        logic unpriv;
    } ctl_bits_t;

    // effective choice: process pointer only in thread mode with select set
    function automatic logic pick_process(input logic in_thread, input logic sel);
        return in_thread & sel;
    endfunction

endpackage

// File: rtl/sp_mode_ctl.sv
module sp_mode_ctl
    import sp_bank_pkg::*;
#(
    parameter int EXC_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_ctl_we,
    input  logic             sw_ctl_sel,
    input  logic             sw_ctl_unpriv,
    input  logic             hw_sel_we,
    input  logic             hw_sel_val,
    input  logic             exc_we,
    input  logic [EXC_W-1:0] exc_val,
    output logic             sel_q,
    output logic             unpriv_q,
    output logic [EXC_W-1:0] exc_q,
    output logic             proc_now,
    output logic             swap
);

    typedef struct packed {
        ctl_bits_t        ctl;
        logic [EXC_W-1:0] exc;
    } mode_st_t;

    mode_st_t st_d, st_q;
    logic     proc_next;

    always_comb begin
        st_d = st_q;
        if (hw_sel_we) begin
            st_d.ctl.sel = hw_sel_val;
        end else if (sw_ctl_we && (st_q.exc == '0)) begin
            st_d.ctl.sel = sw_ctl_sel;
        end
        if (sw_ctl_we) begin
            st_d.ctl.unpriv = sw_ctl_unpriv;
        end
        if (exc_we) begin
            st_d.exc = exc_val;
        end
        proc_now  = pick_process(st_q.exc == '0, st_q.ctl.sel);
        proc_next = pick_process(st_d.exc == '0, st_d.ctl.sel);
        swap      = proc_now ^ proc_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_q    = st_q.ctl.sel;
    assign unpriv_q = st_q.ctl.unpriv;
    assign exc_q    = st_q.exc;

    // R4: a hardware select write always lands
    a_r4_hw_sel_lands: assert property (@(posedge clk) disable iff (!rst_n)
        hw_sel_we |=> sel_q == $past(hw_sel_val));

    // R5: software select write ignored in handler mode
    a_r5_sw_sel_handler: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_ctl_we && !hw_sel_we && exc_q != '0) |=> $stable(sel_q));

    // R6: unprivileged bit follows every software write
    a_r6_unpriv_any_mode: assert property (@(posedge clk) disable iff (!rst_n)
        sw_ctl_we |=> unpriv_q == $past(sw_ctl_unpriv));

    // R3: exception number is taken on write
    a_r3_exc_taken: assert property (@(posedge clk) disable iff (!rst_n)
        exc_we |=> exc_q == $past(exc_val));

endmodule

// File: rtl/sp_bank_store.sv
module sp_bank_store #(
    parameter int SP_W       = 32,
    parameter int ALIGN_BITS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sp_we,
    input  logic [SP_W-1:0] sp_wdata,
    input  logic            swap,
    output logic [SP_W-1:0] live_q,
    output logic [SP_W-1:0] shadow_q
);

    localparam logic [SP_W-1:0] LOW_MASK = (SP_W'(1) << ALIGN_BITS) - SP_W'(1);

    typedef struct packed {
        logic [SP_W-1:0] live;
        logic [SP_W-1:0] shadow;
    } bank_t;

    bank_t bk_d, bk_q;
    logic [SP_W-1:0] wr_aligned;

    always_comb begin
        wr_aligned = sp_wdata & ~LOW_MASK;
        bk_d       = bk_q;
        if (sp_we) begin
            bk_d.live = wr_aligned;
        end
        if (swap) begin
            bk_d.live   = bk_d.shadow;
            bk_d.shadow = sp_we ? wr_aligned : bk_q.live;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bk_q <= '0;
        end else begin
            bk_q <= bk_d;
        end
    end

    assign live_q   = bk_q.live;
    assign shadow_q = bk_q.shadow;

    // R2: without a swap or a write both registers hold
    a_r2_hold_no_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (!swap && !sp_we) |=> ($stable(live_q) && $stable(shadow_q)));

    // R2: a swap exchanges the two registers
    a_r2_swap_exchanges: assert property (@(posedge clk) disable iff (!rst_n)
        (swap && !sp_we) |=> (live_q == $past(shadow_q) && shadow_q == $past(live_q)));

    // R8: stored pointers stay aligned
    a_r8_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        ((live_q & LOW_MASK) == '0) && ((shadow_q & LOW_MASK) == '0));

endmodule

// File: rtl/sp_lookup_mux.sv
module sp_lookup_mux
    import sp_bank_pkg::*;
#(
    parameter int SP_W = 32
) (
    input  logic            lk_thread,
    input  logic            lk_sel,
    input  logic            cur_process,
    input  logic [SP_W-1:0] live,
    input  logic [SP_W-1:0] shadow,
    output logic [SP_W-1:0] lk_data
);

    logic want_process;

    always_comb begin
        want_process = pick_process(lk_thread, lk_sel);
        lk_data      = (want_process == cur_process) ? live : shadow;
    end

endmodule

// File: rtl/sp_bank_select.sv
module sp_bank_select
    import sp_bank_pkg::*;
#(
    parameter int SP_W       = 32,
    parameter int EXC_W      = 9,
    parameter int ALIGN_BITS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_ctl_we,
    input  logic             sw_ctl_sel,
    input  logic             sw_ctl_unpriv,
    input  logic             hw_sel_we,
    input  logic             hw_sel_val,
    input  logic             exc_we,
    input  logic [EXC_W-1:0] exc_val,
    input  logic             sp_we,
    input  logic [SP_W-1:0]  sp_wdata,
    input  logic             lk_thread,
    input  logic             lk_sel,
    output logic [SP_W-1:0]  lk_data,
    output logic [SP_W-1:0]  sp_active,
    output logic             using_process,
    output logic             sel_bit,
    output logic             unpriv_bit,
    output logic [EXC_W-1:0] exc_num
);

    logic            proc_now;
    logic            swap;
    logic [SP_W-1:0] live_q;
    logic [SP_W-1:0] shadow_q;

    sp_mode_ctl #(.EXC_W(EXC_W)) u_mode (
        .clk           (clk),
        .rst_n         (rst_n),
        .sw_ctl_we     (sw_ctl_we),
        .sw_ctl_sel    (sw_ctl_sel),
        .sw_ctl_unpriv (sw_ctl_unpriv),
        .hw_sel_we     (hw_sel_we),
        .hw_sel_val    (hw_sel_val),
        .exc_we        (exc_we),
        .exc_val       (exc_val),
        .sel_q         (sel_bit),
        .unpriv_q      (unpriv_bit),
        .exc_q         (exc_num),
        .proc_now      (proc_now),
        .swap          (swap)
    );

    sp_bank_store #(.SP_W(SP_W), .ALIGN_BITS(ALIGN_BITS)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .sp_we    (sp_we),
        .sp_wdata (sp_wdata),
        .swap     (swap),
        .live_q   (live_q),
        .shadow_q (shadow_q)
    );

    sp_lookup_mux #(.SP_W(SP_W)) u_look (
        .lk_thread   (lk_thread),
        .lk_sel      (lk_sel),
        .cur_process (proc_now),
        .live        (live_q),
        .shadow      (shadow_q),
        .lk_data     (lk_data)
    );

    assign sp_active     = live_q;
    assign using_process = proc_now;

    // R4: select write while in handler and staying there keeps the live pointer
    a_r4_handler_no_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_sel_we && !sw_ctl_we && !exc_we && !sp_we && exc_num != '0) |=> $stable(sp_active));

    // R7: lookup of the live choice returns the live pointer
    a_r7_lookup_live: assert property (@(posedge clk) disable iff (!rst_n)
        ((lk_thread && lk_sel) == using_process) |-> lk_data == sp_active);

    // R1: process pointer never live in handler mode
    a_r1_handler_main: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_num != '0) |-> !using_process);

endmodule

// File: tb/sim_sp_bank_select.sv
module sim_sp_bank_select;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_ctl_we = 0, sw_ctl_sel = 0, sw_ctl_unpriv = 0;
    logic        hw_sel_we = 0, hw_sel_val = 0;
    logic        exc_we = 0;
    logic [8:0]  exc_val = '0;
    logic        sp_we = 0;
    logic [31:0] sp_wdata = '0;
    logic        lk_thread = 0, lk_sel = 0;
    logic [31:0] lk_data, sp_active;
    logic        using_process, sel_bit, unpriv_bit;
    logic [8:0]  exc_num;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // reference state, kept by pointer name
    logic [31:0] m_main = 0, m_proc = 0;
    logic        m_sel = 0, m_unpriv = 0;
    int          m_exc = 0;

    always #2 clk = ~clk;

    sp_bank_select u0 (
        .clk(clk), .rst_n(rst_n),
        .sw_ctl_we(sw_ctl_we), .sw_ctl_sel(sw_ctl_sel), .sw_ctl_unpriv(sw_ctl_unpriv),
        .hw_sel_we(hw_sel_we), .hw_sel_val(hw_sel_val),
        .exc_we(exc_we), .exc_val(exc_val),
        .sp_we(sp_we), .sp_wdata(sp_wdata),
        .lk_thread(lk_thread), .lk_sel(lk_sel),
        .lk_data(lk_data), .sp_active(sp_active), .using_process(using_process),
        .sel_bit(sel_bit), .unpriv_bit(unpriv_bit), .exc_num(exc_num)
    );

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    function automatic bit m_live_proc();
        return (m_exc == 0) && m_sel;
    endfunction

    task automatic compare_all();
        logic [31:0] want;
        chk("R1", "using_process", {31'b0, using_process}, {31'b0, m_live_proc()});
        chk("R2", "sp_active", sp_active, m_live_proc() ? m_proc : m_main);
        chk("R5", "sel_bit", {31'b0, sel_bit}, {31'b0, m_sel});
        chk("R6", "unpriv_bit", {31'b0, unpriv_bit}, {31'b0, m_unpriv});
        chk("R3", "exc_num", {23'b0, exc_num}, m_exc);
        want = (lk_thread && lk_sel) ? m_proc : m_main;
        chk("R7", "lk_data", lk_data, want);
    endtask

    // one clock: inputs already driven; update the model from them, then compare
    task automatic step();
        bit was_proc;
        @(posedge clk);
        was_proc = m_live_proc();
        if (sp_we) begin
            if (was_proc) m_proc = sp_wdata & 32'hFFFF_FFFC;
            else          m_main = sp_wdata & 32'hFFFF_FFFC;
        end
        if (hw_sel_we)                      m_sel = hw_sel_val;
        else if (sw_ctl_we && m_exc == 0)   m_sel = sw_ctl_sel;
        if (sw_ctl_we)                      m_unpriv = sw_ctl_unpriv;
        if (exc_we)                         m_exc = int'(exc_val);
        #1;
        compare_all();
        @(negedge clk);
        sw_ctl_we = 0; hw_sel_we = 0; exc_we = 0; sp_we = 0;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: got hang expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk("R9", "reset sp_active", sp_active, 32'h0);
        chk("R9", "reset using_process", {31'b0, using_process}, 32'h0);
        chk("R9", "reset exc_num", {23'b0, exc_num}, 32'h0);
        compare_all();

        // R8: alignment and target of an SP write
        sp_we = 1; sp_wdata = 32'h0000_1003; step();
        chk("R8", "aligned main", sp_active, 32'h0000_1000);

        // R5: thread-mode software write selects process pointer
        sw_ctl_we = 1; sw_ctl_sel = 1; step();
        sp_we = 1; sp_wdata = 32'h0000_2002; step();
        chk("R8", "process write", sp_active, 32'h0000_2000);

        // R10: exception entry - select cleared and number written together
        hw_sel_we = 1; hw_sel_val = 0; exc_we = 1; exc_val = 9'd11; step();
        chk("R10", "entry live main", sp_active, 32'h0000_1000);
        lk_thread = 1; lk_sel = 1; #0;
        #1; chk("R7", "lookup process", lk_data, 32'h0000_2000);

        // R5/R6: handler-mode software write: select ignored, unpriv taken
        sw_ctl_we = 1; sw_ctl_sel = 1; sw_ctl_unpriv = 1; step();
        chk("R5", "sel ignored in handler", {31'b0, sel_bit}, 32'h0);
        chk("R6", "unpriv in handler", {31'b0, unpriv_bit}, 32'h1);

        // R4: return code loads select while still in handler: no swap
        hw_sel_we = 1; hw_sel_val = 1; step();
        chk("R4", "no swap in handler", sp_active, 32'h0000_1000);

        // R3: writing zero returns to thread and swaps
        exc_we = 1; exc_val = 9'd0; step();
        chk("R3", "return swap", sp_active, 32'h0000_2000);

        // R3: handler to handler changes nothing
        exc_we = 1; exc_val = 9'd3; step();
        exc_we = 1; exc_val = 9'd7; step();
        chk("R3", "handler to handler", sp_active, 32'h0000_1000);
        exc_we = 1; exc_val = 9'd0; step();

        // R10: software select and exception write in one cycle from thread sel=1
        sw_ctl_we = 1; sw_ctl_sel = 0; exc_we = 1; exc_val = 9'd5; step();
        chk("R10", "combined sel", {31'b0, sel_bit}, 32'h0);

        // randomized traffic compared every clock
        for (int i = 0; i < 4000; i++) begin
            sw_ctl_we     = ($urandom_range(0, 5) == 0);
            sw_ctl_sel    = 1'($urandom);
            sw_ctl_unpriv = 1'($urandom);
            hw_sel_we     = ($urandom_range(0, 7) == 0);
            hw_sel_val    = 1'($urandom);
            exc_we        = ($urandom_range(0, 4) == 0);
            exc_val       = ($urandom_range(0, 2) == 0) ? 9'(($urandom_range(1, 511))) : 9'd0;
            sp_we         = ($urandom_range(0, 2) == 0);
            sp_wdata      = $urandom;
            lk_thread     = 1'($urandom);
            lk_sel        = 1'($urandom);
            step();
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule